// File: doc/BRIEF.md
# Clock Source Switch Controller

This block picks which of several free-running source clocks drives a system clock output. Software chooses a source by writing its code into a requested-source field and setting a self-clearing start bit. The controller samples each source's ready indication through a synchronizer. It refuses a source that is not ready, or a code with no source behind it. For a source it accepts, it closes the gate of the old clock on that clock's falling edge and waits until the closure is seen in the register clock domain. It then opens the gate of the new clock, again on a falling edge, so the output never carries a runt pulse. The current-source field shows the clock that actually drives the output, so software learns the outcome by comparing it with its request once the start bit has dropped.

The selected clock then passes through a post-divider whose ratio is a 4-bit field plus one. A ratio change is handed to the output clock domain and takes effect only at the end of a complete divided period. A busy flag stays high until the new ratio is in use, and further writes to the ratio are ignored while it is high. The same register also stores slew enables and a slew step value for software to use.

Register access is a single write port with a one-bit register select (0 = control register, 1 = slew/status register). Both registers are visible at all times on two read-back buses.

Top module: `clk_switch_ctrl`

## Requirements
- R1: After reset, every read-back field is 0. This covers the current source, the requested source, the start bit, the post-divider, the busy flag, the slew enables and the slew step. The output runs at the frequency of source 0.
- R2: In the control register (select 0), writing 1 to bit 0 sets the start bit, and writing 0 to it has no effect. Hardware clears the bit once the switch attempt has ended.
- R3: If the source named in control bits 10:8 reports ready, then once the start bit has cleared, control bits 14:12 equal that code and the output runs at that source's frequency divided by the post-divider ratio.
- R4: No two source gates are open at the same time, and the output never carries a high pulse shorter than the shortest source's high phase.
- R5: A request for a source whose ready input is low, or for a code at or above the number of sources, is rejected. The start bit clears, while control bits 14:12 and the output frequency stay as they were.
- R6: A request naming the current source clears the start bit within 4 register-clock cycles of the write, with no handover.
- R7: Bit 0 of the slew register (select 1) is a read-only busy flag. It rises in the cycle after a write that changes bits 23:20, and falls once the new ratio is in use.
- R8: The output period equals the source period times (bits 23:20 + 1), and a new ratio is loaded only at the end of a full divided period.
- R9: While busy is 1, writes do not change bits 23:20.
- R10: Slew register bit 1 (down-scaling enable), bit 2 (up-scaling enable) and bits 10:8 (slew step) are stored and read back, and have no effect on the output clock.
- R11: Control bits 10:8 read back the last value written, and all unassigned bits of both registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and control clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_clk | input | NUM_SRC | Candidate source clocks |
| src_ready | input | NUM_SRC | Per-source stable/present indications, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Register select: 0 control, 1 slew/status |
| wr_data | input | 32 | Write data |
| ctrl_q | output | 32 | Control register read-back |
| slew_q | output | 32 | Slew/status register read-back |
| clk_out | output | 1 | Gated, post-divided system clock |

## Verification
The switch function is tried with four kinds of request: a ready source, an unready source, a code beyond the implemented sources, and the source already in use. Together they separate an accepted handover from the two kinds of rejection and from the fast path with no handover. After each attempt the output frequency is measured. This shows whether the current-source field agrees with the clock that really drives the output, and whether a rejection leaves the old clock running. The divider is driven with a ratio change, with a second write that lands while busy, and with a write that touches only the slew fields. These separate a ratio being applied from a write being ignored and from a write having no effect. The output's shortest high pulse is tracked over all of these handovers.

// File: rtl/csw_pkg.sv
// Shared constants and types for the clock source switch controller.
// Field positions are fixed by the register layout seen by software.
package csw_pkg;
    localparam int SRC_W    = 3;   // width of a source code
    localparam int PDIV_W   = 4;   // width of the post-divider field
    localparam int STEP_W   = 3;   // width of the slew step field
    localparam int REG_W    = 32;

    // control register
    localparam int CUR_LSB  = 12;
    localparam int REQ_LSB  = 8;
    localparam int SWEN_BIT = 0;

    // slew / status register
    localparam int PDIV_LSB = 20;
    localparam int STEP_LSB = 8;
    localparam int UPEN_BIT = 2;
    localparam int DNEN_BIT = 1;
    localparam int BUSY_BIT = 0;

    typedef enum logic [2:0] {
        SW_IDLE,
        SW_CHECK,
        SW_DROP,
        SW_RAISE,
        SW_DONE
    } sw_state_e;
endpackage

// File: rtl/csw_gate_cell.sv
// One source branch of the glitch-free clock selector.
// Assumes: sel comes from another clock domain and is held for many cycles.
// The enable moves only on the falling edge of the source, so the gated
// clock can only start or stop while the source is low.
module csw_gate_cell #(
    parameter bit RST_ON = 1'b0
) (
    input  logic src_clk,
    input  logic rst_n,
    input  logic sel,
    output logic gate_on,
    output logic gated_clk
);
    logic sync1_q, sync2_q, en_q;

    // Bring the select into the source domain through two flops.
    always_ff @(posedge src_clk) begin
        if (!rst_n) begin
            sync1_q <= RST_ON;
            sync2_q <= RST_ON;
        end else begin
            sync1_q <= sel;
            sync2_q <= sync1_q;
        end
    end

    // Move the gate enable only while the source clock is low.
    always_ff @(negedge src_clk) begin
        if (!rst_n) en_q <= RST_ON;
        else        en_q <= sync2_q;
    end

    assign gate_on   = en_q;
    assign gated_clk = src_clk & en_q;
endmodule

// File: rtl/csw_switch_fsm.sv
// Switch sequencer: accepts or rejects a request, drops the old gate,
// waits for the drop to be seen, raises the new gate and reports done.
// Assumes: gate_on and src_ready are asynchronous and pass through 2 flops.
module csw_switch_fsm
    import csw_pkg::*;
#(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               swen,
    input  logic [SRC_W-1:0]   req,
    input  logic [NUM_SRC-1:0] src_ready,
    input  logic [NUM_SRC-1:0] gate_on,
    output logic [NUM_SRC-1:0] sel,
    output logic [SRC_W-1:0]   cur,
    output logic               done
);
    localparam int NCODE = 1 << SRC_W;

    sw_state_e          st_q;
    logic [SRC_W-1:0]   tgt_q, cur_q;
    logic [NUM_SRC-1:0] sel_q, tgt_onehot;
    logic [NUM_SRC-1:0] rdy_s1, rdy_s2, on_s1, on_s2;
    logic [NCODE-1:0]   rdy_pad, on_pad;
    logic               tgt_ok;

    // Synchronize ready inputs and gate feedback into this domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_s1 <= '0;
            rdy_s2 <= '0;
            on_s1  <= NUM_SRC'(1);
            on_s2  <= NUM_SRC'(1);
        end else begin
            rdy_s1 <= src_ready;
            rdy_s2 <= rdy_s1;
            on_s1  <= gate_on;
            on_s2  <= on_s1;
        end
    end

    // Widen synchronized vectors so any code can index them safely.
    always_comb begin
        rdy_pad = NCODE'(rdy_s2);
        on_pad  = NCODE'(on_s2);
        tgt_ok  = (32'(tgt_q) < NUM_SRC) && rdy_pad[tgt_q];
    end

    // Decode the target code into a gate select pattern.
    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            tgt_onehot[i] = (tgt_q == SRC_W'(i));
        end
    end

    // Sequence state, target latch and current-source tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= SW_IDLE;
            tgt_q <= '0;
            cur_q <= '0;
        end else begin
            case (st_q)
                SW_IDLE: if (swen) begin
                    tgt_q <= req;
                    st_q  <= SW_CHECK;
                end
                SW_CHECK: begin
                    if (tgt_q == cur_q)  st_q <= SW_DONE;
                    else if (tgt_ok)     st_q <= SW_DROP;
                    else                 st_q <= SW_DONE;
                end
                SW_DROP:  if (!on_pad[cur_q]) st_q <= SW_RAISE;
                SW_RAISE: if (on_pad[tgt_q]) begin
                    cur_q <= tgt_q;
                    st_q  <= SW_DONE;
                end
                SW_DONE:  st_q <= SW_IDLE;
                default:  st_q <= SW_IDLE;
            endcase
        end
    end

    // Gate select: closed on an accepted request, reopened on the target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= NUM_SRC'(1);
        end else if (st_q == SW_CHECK && tgt_q != cur_q && tgt_ok) begin
            sel_q <= '0;
        end else if (st_q == SW_DROP && !on_pad[cur_q]) begin
            sel_q <= tgt_onehot;
        end
    end

    assign sel  = sel_q;
    assign cur  = cur_q;
    assign done = (st_q == SW_DONE);

    // R4: the observed gates never overlap.
    assert_one_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(on_s2));
    // R4: at most one gate is ever requested.
    assert_one_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_q));
    // R3: the current source moves only at the end of a raise.
    assert_cur_from_raise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_q) |-> $past(st_q) == SW_RAISE);
    // R5: an attempt ending straight after the check keeps the current source.
    assert_reject_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SW_DONE && $past(st_q) == SW_CHECK) |-> $stable(cur_q));
endmodule

// File: rtl/csw_postdiv.sv
// Post-divider on the selected clock. A new ratio is taken from the register
// domain after a toggle handshake, and only at the end of a divided period.
// Assumes: pdiv is held stable while the request toggle differs from the ack.
module csw_postdiv
    import csw_pkg::*;
(
    input  logic              mux_clk,
    input  logic              rst_n,
    input  logic [PDIV_W-1:0] pdiv,
    input  logic              req_tgl,
    output logic              ack_tgl,
    output logic              clk_out
);
    localparam int RW = PDIV_W + 1;

    logic          t1_q, t2_q, ack_q, div_q;
    logic [RW-1:0] act_q, cnt_q, half, cnt_nx;
    logic          wrap;

    // Bring the request toggle into the divided-clock domain.
    always_ff @(posedge mux_clk) begin
        if (!rst_n) begin
            t1_q <= 1'b0;
            t2_q <= 1'b0;
        end else begin
            t1_q <= req_tgl;
            t2_q <= t1_q;
        end
    end

    // Period boundary and high-phase length of the active ratio.
    always_comb begin
        wrap   = (cnt_q == act_q - RW'(1));
        half   = (act_q + RW'(1)) >> 1;
        cnt_nx = wrap ? '0 : cnt_q + RW'(1);
    end

    // Phase counter and divided level; the ratio is reloaded on a wrap.
    always_ff @(posedge mux_clk) begin
        if (!rst_n) begin
            act_q <= RW'(1);
            cnt_q <= '0;
            ack_q <= 1'b0;
            div_q <= 1'b1;
        end else begin
            cnt_q <= cnt_nx;
            div_q <= (cnt_nx < half);
            if (wrap && (t2_q != ack_q)) begin
                act_q <= RW'(pdiv) + RW'(1);
                ack_q <= t2_q;
            end
        end
    end

    assign ack_tgl = ack_q;
    assign clk_out = (act_q == RW'(1)) ? mux_clk : div_q;

    // R8: the ratio changes only where the previous period ended.
    assert_ratio_at_wrap_R8: assert property (@(posedge mux_clk) disable iff (!rst_n)
        !$stable(act_q) |-> $past(cnt_q) == $past(act_q) - RW'(1));
    // R8: the phase counter stays inside the active ratio.
    assert_cnt_range_R8: assert property (@(posedge mux_clk) disable iff (!rst_n)
        cnt_q < act_q);
endmodule

// File: rtl/csw_regs.sv
// Control and slew/status registers plus the busy flag of the divider
// handshake. Assumes: ack_tgl is asynchronous and passes through 2 flops.
module csw_regs
    import csw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [SRC_W-1:0]  cur,
    input  logic              done,
    input  logic              ack_tgl,
    output logic [REG_W-1:0]  ctrl_q,
    output logic [REG_W-1:0]  slew_q,
    output logic              swen,
    output logic [SRC_W-1:0]  req,
    output logic [PDIV_W-1:0] pdiv,
    output logic              req_tgl
);
    logic              swen_q, tgl_q, a1_q, a2_q, up_q, dn_q, busy;
    logic [SRC_W-1:0]  req_q;
    logic [PDIV_W-1:0] pdiv_q;
    logic [STEP_W-1:0] step_q;
    logic              wr_ctrl, wr_slew;

    assign wr_ctrl = wr_en && !wr_addr;
    assign wr_slew = wr_en &&  wr_addr;

    // Bring the divider acknowledge toggle into this domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a1_q <= 1'b0;
            a2_q <= 1'b0;
        end else begin
            a1_q <= ack_tgl;
            a2_q <= a1_q;
        end
    end

    assign busy = tgl_q ^ a2_q;

    // Control fields: requested code and the self-clearing start bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= '0;
            swen_q <= 1'b0;
        end else begin
            if (wr_ctrl) req_q <= wr_data[REQ_LSB +: SRC_W];
            if (wr_ctrl && wr_data[SWEN_BIT]) swen_q <= 1'b1;
            else if (done)                    swen_q <= 1'b0;
        end
    end

    // Slew fields and divider ratio; a ratio change raises the request toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pdiv_q <= '0;
            step_q <= '0;
            up_q   <= 1'b0;
            dn_q   <= 1'b0;
            tgl_q  <= 1'b0;
        end else if (wr_slew) begin
            step_q <= wr_data[STEP_LSB +: STEP_W];
            up_q   <= wr_data[UPEN_BIT];
            dn_q   <= wr_data[DNEN_BIT];
            if (!busy && wr_data[PDIV_LSB +: PDIV_W] != pdiv_q) begin
                pdiv_q <= wr_data[PDIV_LSB +: PDIV_W];
                tgl_q  <= ~tgl_q;
            end
        end
    end

    // Read-back assembly; unassigned bits stay zero.
    always_comb begin
        ctrl_q = '0;
        ctrl_q[CUR_LSB +: SRC_W] = cur;
        ctrl_q[REQ_LSB +: SRC_W] = req_q;
        ctrl_q[SWEN_BIT]         = swen_q;
        slew_q = '0;
        slew_q[PDIV_LSB +: PDIV_W] = pdiv_q;
        slew_q[STEP_LSB +: STEP_W] = step_q;
        slew_q[UPEN_BIT]           = up_q;
        slew_q[DNEN_BIT]           = dn_q;
        slew_q[BUSY_BIT]           = busy;
    end

    assign swen    = swen_q;
    assign req     = req_q;
    assign pdiv    = pdiv_q;
    assign req_tgl = tgl_q;

    // R2: a finished attempt clears the start bit unless a new start lands.
    assert_swen_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !(wr_ctrl && wr_data[SWEN_BIT])) |=> !swen_q);
    // R9: a slew write while busy leaves the ratio alone.
    assert_pdiv_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_slew) |=> $stable(pdiv_q));
    // R7: busy only rises right after a slew write.
    assert_busy_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_slew));
endmodule

// File: rtl/clk_switch_ctrl.sv
// Top of the clock source switch controller: registers, switch sequencer,
// one gate cell per source, OR-combined selected clock and post-divider.
// Assumes: NUM_SRC is between 2 and 8; all sources run during reset.
module clk_switch_ctrl
    import csw_pkg::*;
#(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_clk,
    input  logic [NUM_SRC-1:0] src_ready,
    input  logic               wr_en,
    input  logic               wr_addr,
    input  logic [31:0]        wr_data,
    output logic [31:0]        ctrl_q,
    output logic [31:0]        slew_q,
    output logic               clk_out
);
    logic               swen, done, req_tgl, ack_tgl, mux_clk;
    logic [SRC_W-1:0]   req, cur;
    logic [PDIV_W-1:0]  pdiv;
    logic [NUM_SRC-1:0] sel, gate_on, gated;

    csw_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cur     (cur),
        .done    (done),
        .ack_tgl (ack_tgl),
        .ctrl_q  (ctrl_q),
        .slew_q  (slew_q),
        .swen    (swen),
        .req     (req),
        .pdiv    (pdiv),
        .req_tgl (req_tgl)
    );

    csw_switch_fsm #(.NUM_SRC(NUM_SRC)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .swen      (swen),
        .req       (req),
        .src_ready (src_ready),
        .gate_on   (gate_on),
        .sel       (sel),
        .cur       (cur),
        .done      (done)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        csw_gate_cell #(.RST_ON(g == 0)) u_gate (
            .src_clk   (src_clk[g]),
            .rst_n     (rst_n),
            .sel       (sel[g]),
            .gate_on   (gate_on[g]),
            .gated_clk (gated[g])
        );
    end

    assign mux_clk = |gated;

    csw_postdiv u_div (
        .mux_clk (mux_clk),
        .rst_n   (rst_n),
        .pdiv    (pdiv),
        .req_tgl (req_tgl),
        .ack_tgl (ack_tgl),
        .clk_out (clk_out)
    );
endmodule

// File: tb/sim_clk_switch_ctrl.sv
`timescale 1ns/1ps
module sim_clk_switch_ctrl;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        sc0 = 1'b0, sc1 = 1'b0, sc2 = 1'b0, sc3 = 1'b0;
    logic [3:0]  src_ready = 4'b1011;
    logic        wr_en = 1'b0, wr_addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] ctrl_q, slew_q;
    logic        clk_out;

    int  checks = 0, errors = 0;
    int  exp_q[$];
    int  pos_cnt = 0;
    real t_rise = 0.0, min_hi = 1.0e9;
    bit  track = 1'b0, prev_swen = 1'b0, finished = 1'b0;

    always #2.5 clk = ~clk;
    always #5   sc0 = ~sc0;
    always #7   sc1 = ~sc1;
    always #11  sc2 = ~sc2;
    always #3   sc3 = ~sc3;

    clk_switch_ctrl #(.NUM_SRC(4)) u0 (
        .clk(clk), .rst_n(rst_n), .src_clk({sc3, sc2, sc1, sc0}),
        .src_ready(src_ready), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ctrl_q(ctrl_q), .slew_q(slew_q), .clk_out(clk_out)
    );

    task automatic check(bit ok, string rq, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // Output edge counting and shortest-high-pulse tracking.
    always @(posedge clk_out) begin
        pos_cnt++;
        t_rise = $realtime;
    end
    always @(negedge clk_out) begin
        if (track && ($realtime - t_rise) < min_hi) min_hi = $realtime - t_rise;
    end

    // Scoreboard monitor: each fall of the start bit pops one expected source.
    always @(negedge clk) begin
        if (rst_n && prev_swen && !ctrl_q[0]) begin
            if (exp_q.size() > 0) begin
                int e;
                e = exp_q.pop_front();
                check(ctrl_q[14:12] == 3'(e), "R3/R5 current source", int'(ctrl_q[14:12]), e);
            end else begin
                check(1'b0, "R2 unexpected completion", 1, 0);
            end
        end
        prev_swen = ctrl_q[0];
    end

    task automatic bus_write(bit addr, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = addr; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic wait_swen_clear(string rq);
        int n = 0;
        while (ctrl_q[0] && n < 4000) begin
            @(negedge clk);
            n++;
        end
        check(!ctrl_q[0], rq, int'(ctrl_q[0]), 0);
        @(negedge clk);
    endtask

    task automatic wait_busy_clear(string rq);
        int n = 0;
        while (slew_q[0] && n < 4000) begin
            @(negedge clk);
            n++;
        end
        check(!slew_q[0], rq, int'(slew_q[0]), 0);
    endtask

    // Driver: queue the expected outcome, then request the switch.
    task automatic do_switch(int code, int exp_cur, string rq);
        exp_q.push_back(exp_cur);
        bus_write(1'b0, (32'(code) << 8) | 32'h1);
        wait_swen_clear(rq);
    endtask

    task automatic measure(real period, string rq);
        int  n;
        real e;
        pos_cnt = 0;
        #4000;
        n = pos_cnt;
        e = 4000.0 / period;
        check((real'(n) >= e - 2.0) && (real'(n) <= e + 2.0), rq, n, int'(e));
    endtask

    initial begin
        int n;
        repeat (20) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(ctrl_q == 32'h0, "R1 control reset", int'(ctrl_q), 0);
        check(slew_q == 32'h0, "R1 slew reset", int'(slew_q), 0);
        track = 1'b1;
        measure(10.0, "R1 output follows source 0");

        // R2 / R11: writing 0 to the start bit does nothing; request field reads back
        bus_write(1'b0, 32'h0000_0200);
        repeat (3) @(negedge clk);
        check(ctrl_q == 32'h0000_0200, "R2 R11 start bit write 0 ignored", int'(ctrl_q), 32'h200);

        // R3: accepted switch to source 1
        do_switch(1, 1, "R3 switch to 1 completes");
        measure(14.0, "R3 output follows source 1");

        // R5: unready source 2 and out-of-range code 5 are rejected
        do_switch(2, 1, "R5 unready completes");
        measure(14.0, "R5 output kept after unready request");
        do_switch(5, 1, "R5 bad code completes");
        check(ctrl_q[10:8] == 3'd5, "R11 request field", int'(ctrl_q[10:8]), 5);

        // R6: request for the current source finishes within 4 cycles
        exp_q.push_back(1);
        bus_write(1'b0, 32'h0000_0101);
        n = 1;
        while (ctrl_q[0] && n < 20) begin
            @(negedge clk);
            n++;
        end
        check(n <= 4, "R6 same source latency", n, 4);
        @(negedge clk);

        // R7 / R8: ratio 4 on source 1
        bus_write(1'b1, 32'h0030_0000);
        check(slew_q[0] == 1'b1, "R7 busy rises", int'(slew_q[0]), 1);
        wait_busy_clear("R7 busy falls");
        check(slew_q[23:20] == 4'd3, "R8 ratio field", int'(slew_q[23:20]), 3);
        measure(56.0, "R8 divide by 4");

        // R9: second write while busy is ignored
        bus_write(1'b1, 32'h0010_0000);
        bus_write(1'b1, 32'h0070_0000);
        wait_busy_clear("R9 busy falls");
        check(slew_q[23:20] == 4'd1, "R9 ratio write while busy ignored", int'(slew_q[23:20]), 1);
        measure(28.0, "R8 divide by 2");

        // R10 / R7: slew fields stored, busy bit read-only, no effect on output
        bus_write(1'b1, 32'h0010_0507);
        @(negedge clk);
        check(slew_q == 32'h0010_0506, "R10 slew fields read back", int'(slew_q), 32'h0010_0506);
        measure(28.0, "R10 slew fields no effect");

        // R3: switch to the fastest source with ratio 2
        do_switch(3, 3, "R3 switch to 3 completes");
        measure(12.0, "R3 R8 source 3 divided by 2");

        // R5 vs R3: source 2 becomes ready and is then accepted
        src_ready = 4'b1111;
        repeat (5) @(negedge clk);
        do_switch(2, 2, "R3 switch to 2 completes");
        measure(44.0, "R3 source 2 divided by 2");
        do_switch(0, 0, "R3 switch to 0 completes");
        measure(20.0, "R3 source 0 divided by 2");

        // R4: no runt high pulse across all handovers
        check(min_hi >= 2.9, "R4 shortest high pulse ns", int'(min_hi), 3);
        check(exp_q.size() == 0, "R2 all attempts completed", exp_q.size(), 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #750000;
        if (!finished) begin
            check(1'b0, "R2 watchdog expired", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule